// File: doc/BRIEF.md
# Workspace-Pointer Register File Front End

This block gives a small processor its general-purpose registers without a register array. The registers are words of a single-port synchronous RAM. A workspace pointer marks the first byte of a window of sixteen 16-bit words, and register n is the word at byte address `wp + 2*n`. Register reads and writes from the datapath are turned into RAM accesses at that address. Moving the pointer moves the whole register set.

Five commands are sequenced on the same RAM port:
- The context-switching call fetches a new pointer and a new program counter from a two-word vector at a fixed byte address. It then stores the old pointer, old program counter and old status into the new window.
- The context return reloads all three from the current window.
- The plain call only stores the current program counter as a return link and jumps.
- The two pointer adjust commands add a byte offset to the pointer or subtract one from it, so the window can slide like a stack frame.

Top module: `wsreg_frontend`

## Requirements
- R1: After reset the pointer (`wp`), program counter (`pc`) and status (`st`) are 0, and `busy` and `done` are low.
- R2: Register n maps to RAM byte address `wp + 2*n`. After the pointer moves by 2*k bytes, index n-k returns the word that index n returned before the move.
- R3: A register access is taken on the edge where its grant is high. A write stores its data. A read raises `rd_valid` one cycle after the grant edge, and `rd_data` then holds the stored word.
- R4: Command 1 (context call, `cmd_arg` = vector byte address A) keeps `busy` high for exactly 5 cycles. It then loads `wp` from the word at A and `pc` from the word at A+2. A is absolute and does not depend on `wp`.
- R5: The context call writes the old `wp` to register 13, the old `pc` to register 14 and the old `st` to register 15 of the new window.
- R6: Command 3 (plain call) keeps `busy` high for 1 cycle, stores the old `pc` into register 11, loads `pc` from `cmd_arg` and leaves `wp` unchanged.
- R7: Command 4 adds `cmd_arg` to `wp` and command 5 subtracts it. Each takes 1 busy cycle, and bit 0 of the result is cleared, so the pointer is always even.
- R8: Command 2 (context return) keeps `busy` high for 4 cycles. It then restores `wp`, `pc` and `st` from registers 13, 14 and 15 of the current window.
- R9: While `busy` is high, or in a cycle where `cmd_valid` is high, neither register grant is given. A read held across a command is granted in the first cycle after `done`, so it sees the new window.
- R10: At most one RAM access takes place per cycle. The command sequencer, the write grant and the read grant are mutually exclusive.
- R11: Command codes 0, 6 and 7 do nothing: `busy` stays low and `wp`, `pc` and `st` keep their values. Commands are sampled only while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, sampled while busy is low |
| cmd_op | input | 3 | Command code (1 ctx call, 2 ctx return, 3 plain call, 4 add, 5 sub) |
| cmd_arg | input | DATA_W | Vector address, jump target or pointer offset |
| busy | output | 1 | Command sequence in progress |
| done | output | 1 | Last cycle of a command sequence |
| rd_req | input | 1 | Register read request, held until granted |
| rd_idx | input | IDX_W | Register number to read |
| rd_gnt | output | 1 | Read taken at this edge |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| wr_req | input | 1 | Register write request, held until granted |
| wr_idx | input | IDX_W | Register number to write |
| wr_data | input | DATA_W | Write data |
| wr_gnt | output | 1 | Write taken at this edge |
| wp | output | ADDR_W | Workspace pointer (byte address) |
| pc | output | DATA_W | Program counter |
| st | output | DATA_W | Status word |

## Verification
Two things can collide here: a datapath register read and a multi-cycle call sequence, since both need the one RAM port. The bench raises a read of register 13 in the same cycle as a context-call command and holds it. It checks that the grant stays low through every busy cycle, including the `done` cycle, and that the grant comes in the cycle right after `done`. The returned word must be the old pointer just saved in the new window, not the contents of the old window.

// File: rtl/wsreg_pkg.sv
// Shared command codes and sequencer states for the workspace register
// front end. Assumes a 3-bit command field.
package wsreg_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_CTX   = 3'd1,
        OP_RET   = 3'd2,
        OP_LINK  = 3'd3,
        OP_ADD   = 3'd4,
        OP_SUB   = 3'd5
    } ws_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_VEC0, S_VEC1, S_SAV0, S_SAV1, S_SAV2,
        S_RET0, S_RET1, S_RET2, S_RET3, S_LINK, S_ADJ
    } ws_state_e;
endpackage

// File: rtl/wsreg_ram.sv
// Single-port synchronous RAM, one access per cycle, registered read data.
// Assumes the caller never needs read and write of the same word in one cycle.
module wsreg_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: perform the single access of this cycle.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    q <= mem[addr];
        end
    end
endmodule

// File: rtl/wsreg_seq.sv
// Command sequencer: owns the workspace pointer, program counter and status,
// and drives the RAM for context call/return, plain call and pointer adjust.
// Assumes the RAM returns read data one cycle after the address and that the
// top gives this block the RAM port whenever busy is high.
module wsreg_seq
    import wsreg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 16,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_arg,
    input  logic [DATA_W-1:0] ram_q,
    output logic              seq_en,
    output logic              seq_we,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [DATA_W-1:0] seq_wdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] wp,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] st
);
    localparam int SAVE_WP = NREG - 3;
    localparam int SAVE_PC = NREG - 2;
    localparam int SAVE_ST = NREG - 1;
    localparam int LINK_R  = NREG - 5;

    ws_state_e         state;
    logic [ADDR_W-1:0] wp_q, nwp_q, vec_q;
    logic [DATA_W-1:0] pc_q, st_q, npc_q, arg_q;
    logic              sub_q;

    function automatic logic [ADDR_W-1:0] reg_at(input logic [ADDR_W-1:0] base, input int idx);
        return base + ADDR_W'(2 * idx);
    endfunction

    function automatic logic [ADDR_W-1:0] even(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:1], 1'b0};
    endfunction

    // Purpose: advance the command state machine and update architectural state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            wp_q  <= '0;
            pc_q  <= '0;
            st_q  <= '0;
            nwp_q <= '0;
            npc_q <= '0;
            vec_q <= '0;
            arg_q <= '0;
            sub_q <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (cmd_valid) begin
                    vec_q <= even(cmd_arg[ADDR_W-1:0]);
                    arg_q <= cmd_arg;
                    sub_q <= (cmd_op == OP_SUB);
                    case (cmd_op)
                        OP_CTX:         state <= S_VEC0;
                        OP_RET:         state <= S_RET0;
                        OP_LINK:        state <= S_LINK;
                        OP_ADD, OP_SUB: state <= S_ADJ;
                        default:        state <= S_IDLE;
                    endcase
                end
                S_VEC0: state <= S_VEC1;
                S_VEC1: begin
                    nwp_q <= even(ram_q[ADDR_W-1:0]);
                    state <= S_SAV0;
                end
                S_SAV0: begin
                    npc_q <= ram_q;
                    state <= S_SAV1;
                end
                S_SAV1: state <= S_SAV2;
                S_SAV2: begin
                    wp_q  <= nwp_q;
                    pc_q  <= npc_q;
                    state <= S_IDLE;
                end
                S_RET0: state <= S_RET1;
                S_RET1: begin
                    nwp_q <= even(ram_q[ADDR_W-1:0]);
                    state <= S_RET2;
                end
                S_RET2: begin
                    npc_q <= ram_q;
                    state <= S_RET3;
                end
                S_RET3: begin
                    wp_q  <= nwp_q;
                    pc_q  <= npc_q;
                    st_q  <= ram_q;
                    state <= S_IDLE;
                end
                S_LINK: begin
                    pc_q  <= arg_q;
                    state <= S_IDLE;
                end
                S_ADJ: begin
                    wp_q  <= even(sub_q ? wp_q - arg_q[ADDR_W-1:0] : wp_q + arg_q[ADDR_W-1:0]);
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Purpose: drive the RAM port and handshake outputs from the current state.
    always_comb begin
        seq_en    = 1'b0;
        seq_we    = 1'b0;
        seq_addr  = '0;
        seq_wdata = '0;
        case (state)
            S_VEC0: begin seq_en = 1'b1; seq_addr = vec_q; end
            S_VEC1: begin seq_en = 1'b1; seq_addr = vec_q + ADDR_W'(2); end
            S_SAV0: begin seq_en = 1'b1; seq_we = 1'b1;
                          seq_addr = reg_at(nwp_q, SAVE_WP); seq_wdata = DATA_W'(wp_q); end
            S_SAV1: begin seq_en = 1'b1; seq_we = 1'b1;
                          seq_addr = reg_at(nwp_q, SAVE_PC); seq_wdata = pc_q; end
            S_SAV2: begin seq_en = 1'b1; seq_we = 1'b1;
                          seq_addr = reg_at(nwp_q, SAVE_ST); seq_wdata = st_q; end
            S_RET0: begin seq_en = 1'b1; seq_addr = reg_at(wp_q, SAVE_WP); end
            S_RET1: begin seq_en = 1'b1; seq_addr = reg_at(wp_q, SAVE_PC); end
            S_RET2: begin seq_en = 1'b1; seq_addr = reg_at(wp_q, SAVE_ST); end
            S_LINK: begin seq_en = 1'b1; seq_we = 1'b1;
                          seq_addr = reg_at(wp_q, LINK_R); seq_wdata = pc_q; end
            default: ;
        endcase
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_SAV2) || (state == S_RET3) || (state == S_LINK) || (state == S_ADJ);
    assign wp   = wp_q;
    assign pc   = pc_q;
    assign st   = st_q;

    // R4: the vector second word is read right after the first, two bytes on
    a_r4_vector_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_VEC0) |=> (state == S_VEC1 && seq_addr == $past(seq_addr) + ADDR_W'(2)));
    // R6: a plain call never moves the workspace pointer
    a_r6_link_keeps_wp: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LINK) |=> $stable(wp_q));
    // R7: the pointer stays even
    a_r7_wp_even: assert property (@(posedge clk) disable iff (!rst_n)
        wp_q[0] == 1'b0);
    // R8: a return reads its three save slots in ascending order
    a_r8_ret_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RET0) |=> (seq_addr == $past(seq_addr) + ADDR_W'(2) && !seq_we));
endmodule

// File: rtl/wsreg_frontend.sv
// Workspace register front end: maps register numbers onto a RAM window at
// the workspace pointer and shares the single RAM port between datapath
// register accesses and the command sequencer. Assumes requesters hold
// rd_req / wr_req until the matching grant is seen.
module wsreg_frontend
    import wsreg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 16,
    parameter int DEPTH  = 256,
    localparam int IDX_W  = $clog2(NREG),
    localparam int ADDR_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_arg,
    output logic              busy,
    output logic              done,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_gnt,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_req,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_gnt,
    output logic [ADDR_W-1:0] wp,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] st
);
    logic              seq_en, seq_we, ram_en, ram_we;
    logic [ADDR_W-1:0] seq_addr, ram_baddr;
    logic [DATA_W-1:0] seq_wdata, ram_wdata, ram_q;
    logic              rd_valid_q;

    wsreg_seq #(.DATA_W(DATA_W), .NREG(NREG), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .ram_q(ram_q), .seq_en(seq_en), .seq_we(seq_we),
        .seq_addr(seq_addr), .seq_wdata(seq_wdata), .busy(busy), .done(done),
        .wp(wp), .pc(pc), .st(st)
    );

    // Purpose: grant a datapath access only when neither a sequence nor a new command owns the port.
    always_comb begin
        wr_gnt = wr_req && !busy && !cmd_valid;
        rd_gnt = rd_req && !busy && !cmd_valid && !wr_req;
    end

    // Purpose: select the RAM port owner and form the byte address.
    always_comb begin
        ram_en    = seq_en || wr_gnt || rd_gnt;
        ram_we    = seq_en ? seq_we : wr_gnt;
        ram_wdata = seq_en ? seq_wdata : wr_data;
        if (seq_en)      ram_baddr = seq_addr;
        else if (wr_gnt) ram_baddr = wp + ADDR_W'({wr_idx, 1'b0});
        else             ram_baddr = wp + ADDR_W'({rd_idx, 1'b0});
    end

    wsreg_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_baddr[ADDR_W-1:1]),
        .wdata(ram_wdata), .q(ram_q)
    );

    // Purpose: flag read data one cycle after its grant.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid_q <= 1'b0;
        else        rd_valid_q <= rd_gnt;
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = ram_q;

    // R9: no register grant while a sequence runs
    a_r9_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_gnt || wr_gnt) |-> !busy);
    // R9: done only ever falls inside a busy window
    a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R10: one RAM user per cycle
    a_r10_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seq_en, rd_gnt, wr_gnt}));
    // R3: valid read data follows a read grant
    a_r3_valid_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gnt |=> rd_valid);
endmodule

// File: tb/sim_wsreg_frontend.sv
module sim_wsreg_frontend;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 4;
    localparam int ADDR_W = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [DATA_W-1:0] cmd_arg = '0;
    logic              busy, done;
    logic              rd_req = 1'b0;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic              rd_gnt, rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              wr_req = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_gnt;
    logic [ADDR_W-1:0] wp;
    logic [DATA_W-1:0] pc, st;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wsreg_frontend u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .busy(busy), .done(done), .rd_req(rd_req),
        .rd_idx(rd_idx), .rd_gnt(rd_gnt), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(wr_data), .wr_gnt(wr_gnt),
        .wp(wp), .pc(pc), .st(st)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic do_write(input int idx, input int data);
        @(negedge clk);
        wr_req = 1'b1; wr_idx = IDX_W'(idx); wr_data = DATA_W'(data);
        #1;
        while (!wr_gnt) begin @(negedge clk); #1; end
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic do_read(input int idx, output int data, output int valid);
        @(negedge clk);
        rd_req = 1'b1; rd_idx = IDX_W'(idx);
        #1;
        while (!rd_gnt) begin @(negedge clk); #1; end
        @(negedge clk);
        rd_req = 1'b0;
        data = int'(rd_data); valid = int'(rd_valid);
    endtask

    task automatic do_cmd(input int op, input int arg, output int ncyc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_arg = DATA_W'(arg);
        @(negedge clk);
        cmd_valid = 1'b0;
        ncyc = 0;
        while (busy) begin ncyc++; @(negedge clk); end
    endtask

    task automatic t_reset;
        check("R1 wp", int'(wp), 0);
        check("R1 pc", int'(pc), 0);
        check("R1 st", int'(st), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
    endtask

    task automatic t_regs_and_window;
        int d, v, n;
        do_write(0, 16'h0040);
        do_write(1, 16'h1234);
        do_write(5, 16'hBEEF);
        do_read(5, d, v);
        check("R3 rd_valid", v, 1);
        check("R3 read back", d, 16'hBEEF);
        do_cmd(4, 4, n);
        check("R7 add cycles", n, 1);
        check("R7 add wp", int'(wp), 4);
        do_read(3, d, v);
        check("R2 slid window", d, 16'hBEEF);
        do_cmd(5, 4, n);
        check("R7 sub wp", int'(wp), 0);
        do_cmd(4, 3, n);
        check("R7 odd add aligned", int'(wp), 2);
        do_cmd(5, 2, n);
        check("R7 back to zero", int'(wp), 0);
    endtask

    task automatic t_plain_call;
        int d, v, n;
        do_cmd(3, 16'h0050, n);
        do_cmd(3, 16'h0100, n);
        check("R6 cycles", n, 1);
        check("R6 pc", int'(pc), 16'h0100);
        check("R6 wp unchanged", int'(wp), 0);
        do_read(11, d, v);
        check("R6 link in r11", d, 16'h0050);
    endtask

    task automatic t_return;
        int n;
        do_write(13, 16'h0010);
        do_write(14, 16'h0200);
        do_write(15, 16'h00A5);
        do_cmd(2, 0, n);
        check("R8 cycles", n, 4);
        check("R8 wp", int'(wp), 16'h0010);
        check("R8 pc", int'(pc), 16'h0200);
        check("R8 st", int'(st), 16'h00A5);
    endtask

    task automatic t_context_call;
        int d, v, n;
        do_cmd(1, 0, n);
        check("R4 cycles", n, 5);
        check("R4 wp from vector", int'(wp), 16'h0040);
        check("R4 pc from vector", int'(pc), 16'h1234);
        do_read(13, d, v);
        check("R5 saved wp", d, 16'h0010);
        do_read(14, d, v);
        check("R5 saved pc", d, 16'h0200);
        do_read(15, d, v);
        check("R5 saved st", d, 16'h00A5);
        do_cmd(2, 0, n);
        check("R8 round trip wp", int'(wp), 16'h0010);
        check("R8 round trip pc", int'(pc), 16'h0200);
    endtask

    task automatic t_read_during_call;
        int waited = 0;
        int saw_done = 0;
        int gnt_busy = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_arg = '0;
        rd_req = 1'b1; rd_idx = 4'd13;
        #1;
        if (rd_gnt) gnt_busy++;
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        while (!rd_gnt) begin
            if (done) saw_done = 1;
            waited++;
            @(negedge clk); #1;
        end
        if (busy) gnt_busy++;
        @(negedge clk);
        rd_req = 1'b0;
        check("R9 no grant with cmd or busy", gnt_busy, 0);
        check("R9 grant right after done", saw_done * 100 + waited, 105);
        check("R9 read sees new window", int'(rd_data), 16'h0010);
    endtask

    task automatic t_ignored_codes;
        int n;
        do_cmd(7, 16'h0123, n);
        check("R11 code 7 no busy", n, 0);
        do_cmd(0, 16'h0123, n);
        check("R11 code 0 no busy", n, 0);
        check("R11 wp kept", int'(wp), 16'h0040);
        check("R11 pc kept", int'(pc), 16'h1234);
        check("R11 st kept", int'(st), 16'h00A5);
    endtask

    // R10: the bench watches that the two datapath grants never coincide
    always @(negedge clk) begin
        if (rst_n && rd_gnt && wr_gnt) begin
            fails++; checks++;
            $display("FAIL R10 both grants actual=1 expected=0");
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs_and_window;
        t_plain_call;
        t_return;
        t_context_call;
        t_read_during_call;
        t_ignored_codes;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule